// File: doc/BRIEF.md
# Free-Running Idle Tick Timer

This block is a 16-bit down counter that runs for as long as the core is clocked. It decrements once for each instruction-cycle enable. Nothing can read it, load it or preset it. Bit 12 of the count changes state once every 4096 enabled cycles. Each of these changes is turned into two things: a single-cycle wake pulse, and a sticky pending flag.

The wake pulse is meant for neighbouring logic. It can end an idle state, or it can count out a start-up delay after a halt. The pending flag drives an interrupt request, and software masks that request with an enable flag. The only software access is a write port for the enable flag and a clear strobe for the pending flag. Because the count has no load path, the tick phase is fixed by the release of reset.

Top module: `idle_tick_timer`

## Requirements
- R1: On each rising clock edge with `cyc_en_i` high, the internal count decreases by one. It wraps from 0x0000 to 0xFFFF. After reset the count is 0xFFFF.
- R2: On an edge with `cyc_en_i` low, the count holds its value, so no wake pulse comes due.
- R3: After reset release with `cyc_en_i` held high, `wake_o` is low through the first 4095 edges. It is high for exactly one clock after the 4096th edge.
- R4: Wake pulses repeat every 4096 enabled cycles, on both the falling and the rising change of bit 12.
- R5: `irq_o` is high exactly when the pending flag and the enable flag are both set. The enable flag is loaded from `en_wdata_i` on an edge with `en_wr_i` high.
- R6: After reset, `pnd_o`, `irq_o` and `wake_o` are low, and the enable flag is clear.
- R7: The pending flag is set on the edge that ends a wake cycle. It stays set until an edge with `pnd_clr_i` high clears it.
- R8: If `pnd_clr_i` is high in the same cycle as `wake_o`, the pending flag is set after that edge.
- R9: Writes to the enable flag and clears of the pending flag do not change when wake pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable, one decrement per high cycle |
| en_wr_i | input | 1 | Write strobe for the interrupt enable flag |
| en_wdata_i | input | 1 | New value of the enable flag |
| pnd_clr_i | input | 1 | Clears the pending flag |
| pnd_o | output | 1 | Pending flag |
| irq_o | output | 1 | Interrupt request, pending AND enable |
| wake_o | output | 1 | One-cycle pulse on each bit-12 change |

## Verification
Two events can meet in one cycle: the software clear of the pending flag and a fresh bit-12 change that sets it. The bench runs the counter to the cycle in which `wake_o` is high and raises `pnd_clr_i` in that same cycle. It then expects the pending flag to be set after the edge, so the new event wins. A plain clear given one cycle later must then drop the flag.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef struct packed {
    logic pnd;
    logic en;
  } itmr_flags_t;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntRst = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CntRst;
    else if (cyc_en_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/itmr_toggle_det.sv
module itmr_toggle_det #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TAP_BIT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tgl_o
);
  // must match tap bit of the all-ones reset count
  localparam logic TapRst = 1'b1;

  logic tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= TapRst;
    else         tap_q <= cnt_i[TAP_BIT];
  end

  assign tgl_o = cnt_i[TAP_BIT] ^ tap_q;
endmodule

// File: rtl/itmr_flags.sv
module itmr_flags
  import itmr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_i,
  input  logic        clr_i,
  input  logic        en_wr_i,
  input  logic        en_wdata_i,
  output itmr_flags_t flags_o
);
  itmr_flags_t q, d;

  always_comb begin
    d = q;
    // new event wins over a clear in the same cycle
    if (set_i)      d.pnd = 1'b1;
    else if (clr_i) d.pnd = 1'b0;
    if (en_wr_i)    d.en  = en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;
endmodule

// File: rtl/idle_tick_timer.sv
module idle_tick_timer
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TAP_BIT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic pnd_clr_i,
  output logic pnd_o,
  output logic irq_o,
  output logic wake_o
);
  logic [CNT_W-1:0] cnt;
  logic             tgl;
  itmr_flags_t      flags;

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_en_i (cyc_en_i),
    .cnt_o    (cnt)
  );

  itmr_toggle_det #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT)) u_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt),
    .tgl_o  (tgl)
  );

  itmr_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (tgl),
    .clr_i      (pnd_clr_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .flags_o    (flags)
  );

  assign wake_o = tgl;
  assign pnd_o  = flags.pnd;
  assign irq_o  = flags.pnd & flags.en;
endmodule

// File: rtl/idle_tick_timer_chk.sv
module idle_tick_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             pnd_clr_i,
  input logic             pnd_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic [CNT_W-1:0] cnt
);
  AST_COUNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_i |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> $stable(cnt)); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R3
  AST_IRQ_NEEDS_PND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pnd_o); // R5
  AST_PND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pnd_o && !pnd_clr_i) |=> pnd_o); // R7
  AST_PND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pnd_clr_i && !wake_o) |=> !pnd_o); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> pnd_o); // R8
endmodule

bind idle_tick_timer idle_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cyc_en_i  (cyc_en_i),
  .pnd_clr_i (pnd_clr_i),
  .pnd_o     (pnd_o),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .cnt       (cnt)
);

// File: tb/idle_tick_timer_tb_top.sv
`timescale 1ns/1ps
module idle_tick_timer_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_en_i = 1'b0, en_wr_i = 1'b0, en_wdata_i = 1'b0, pnd_clr_i = 1'b0;
  logic pnd_o, irq_o, wake_o;
  int   errors = 0;
  int   checks = 0;

  always #10 clk_i = ~clk_i;

  idle_tick_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i), .en_wr_i(en_wr_i),
    .en_wdata_i(en_wdata_i), .pnd_clr_i(pnd_clr_i),
    .pnd_o(pnd_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cyc_en_i = 1'b1; en_wr_i = 1'b0; en_wdata_i = 1'b0; pnd_clr_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R6", "pnd after reset", pnd_o, 0);
    chk("R6", "irq after reset", irq_o, 0);
    chk("R6", "wake after reset", wake_o, 0);
  endtask

  task automatic t_first_and_period();
    do_reset();
    step(4095);
    chk("R3", "wake at edge 4095", wake_o, 0);
    chk("R7", "pnd before first event", pnd_o, 0);
    step(1);
    chk("R3", "wake at edge 4096", wake_o, 1);
    step(1);
    chk("R3", "wake at edge 4097", wake_o, 0);
    chk("R7", "pnd after event", pnd_o, 1);
    step(4094);
    chk("R4", "wake at edge 8191", wake_o, 0);
    step(1);
    chk("R4", "wake at edge 8192", wake_o, 1);
    step(1);
    chk("R4", "wake at edge 8193", wake_o, 0);
  endtask

  task automatic t_irq_gate();
    do_reset();
    step(4097);
    chk("R5", "irq with enable clear", irq_o, 0);
    en_wr_i = 1'b1; en_wdata_i = 1'b1;
    step(1);
    en_wr_i = 1'b0;
    chk("R5", "irq with enable set", irq_o, 1);
    en_wr_i = 1'b1; en_wdata_i = 1'b0;
    step(1);
    en_wr_i = 1'b0;
    chk("R5", "irq after enable cleared", irq_o, 0);
    chk("R7", "pnd held", pnd_o, 1);
    step(20);
    chk("R7", "pnd still held", pnd_o, 1);
  endtask

  task automatic t_clear_collision();
    do_reset();
    en_wr_i = 1'b1; en_wdata_i = 1'b1;
    step(1);
    en_wr_i = 1'b0;
    pnd_clr_i = 1'b1;   // clears and writes must not shift timing (R9)
    step(1);
    pnd_clr_i = 1'b0;
    step(4094);
    chk("R9", "wake at edge 4096 despite writes", wake_o, 1);
    pnd_clr_i = 1'b1;
    step(1);
    pnd_clr_i = 1'b0;
    chk("R8", "pnd set despite clear in wake cycle", pnd_o, 1);
    chk("R5", "irq with pnd and enable", irq_o, 1);
    pnd_clr_i = 1'b1;
    step(1);
    pnd_clr_i = 1'b0;
    chk("R7", "pnd after plain clear", pnd_o, 0);
    chk("R5", "irq after clear", irq_o, 0);
  endtask

  task automatic t_stall();
    int seen;
    do_reset();
    cyc_en_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 10000; i++) begin
      step(1);
      if (wake_o) seen++;
    end
    chk("R2", "wake pulses while stalled", seen, 0);
    cyc_en_i = 1'b1;
    step(4095);
    chk("R2", "wake one edge early after stall", wake_o, 0);
    step(1);
    chk("R2", "wake after 4096 enabled edges", wake_o, 1);
  endtask

  task automatic t_sparse_enable();
    int en_cnt, first_at, pulses;
    do_reset();
    en_cnt = 0; first_at = -1; pulses = 0;
    for (int k = 0; k < 8300; k++) begin
      cyc_en_i = k[0];
      step(1);
      if (cyc_en_i) en_cnt++;
      if (wake_o) begin
        pulses++;
        if (first_at < 0) first_at = en_cnt;
      end
    end
    chk("R1", "enabled count at first wake", first_at, 4096);
    chk("R1", "wake pulses over 4150 enabled edges", pulses, 1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_first_and_period();
    t_irq_gate();
    t_clear_collision();
    t_stall();
    t_sparse_enable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule